// File: doc/BRIEF.md
# Loop Mode State Controller

This block decides the operating mode of a clock tracking loop and picks the frequency word the loop's oscillator should use. On its own it walks among four states (free-run, pre-lock, locked and holdover) using a reference-valid flag, a lock-detect flag and a one-second tick. Software can take the state machine over at any time and command a state directly.

While the loop tracks a reference, the live frequency word passes straight through. In holdover, one of three held values is applied:
- the last word seen while locked,
- the floor average of a power-of-two window of samples taken after a one-second tick,
- the nominal free-run word.

A sticky flag reports every state change until software clears it. The phase detector and loop filter sit outside this block.

Top module: `loop_mode_ctrl`

## Requirements
- R1: After a synchronous reset, `state` is free-run (code 0), `irq_state_chg` is 0 and `freq_out` equals `cfg_freerun_word`. State codes are: 0 free-run, 1 pre-lock, 2 locked, 3 holdover.
- R2: In automatic mode, free-run moves to pre-lock one cycle after `ref_valid` is high. Pre-lock returns to free-run one cycle after `ref_valid` is low.
- R3: In pre-lock, each `tick_1s` seen with `lock_det` high advances a count. The state becomes locked on the edge of the tick that brings the count to `cfg_lock_ticks`, where 0 counts as 1. Any cycle with `lock_det` low clears the count.
- R4: In automatic mode, locked moves to holdover one cycle after `ref_valid` is low. With `ref_valid` high and `lock_det` low, locked moves to pre-lock instead.
- R5: Holdover moves to pre-lock one cycle after `ref_valid` returns high.
- R6: In free-run, `freq_out` is `cfg_freerun_word`. In pre-lock and locked, `freq_out` is the live `freq_in`.
- R7: In holdover with `hold_mode` 0, `freq_out` is the `freq_in` value from the last clock edge that occurred in the locked state. If no such edge has occurred since reset, the value is 0.
- R8: In holdover with `hold_mode` 1, `freq_out` is the floor of the sum of the 2^AVG_LOG2 `freq_in` samples taken on the edges after a tick, divided by 2^AVG_LOG2. This value is published at the next tick only if the window filled while locked. If nothing has ever been published, `freq_out` is `cfg_freerun_word`.
- R9: The averaged value changes only while the state is locked; it is frozen in every other state.
- R10: In holdover with `hold_mode` 2 or 3, `freq_out` is `cfg_freerun_word`.
- R11: While `sw_manual` is high, `state` takes the value of `sw_state` one cycle later, and reference and lock inputs have no effect.
- R12: `irq_state_chg` is set on every state change and cleared by a cycle with `sw_irq_clr` high. If a change and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | Selected reference is usable |
| lock_det | input | 1 | Loop reports phase lock |
| tick_1s | input | 1 | One-cycle pulse once per second |
| freq_in | input | FW | Current frequency word from the loop |
| sw_manual | input | 1 | Software owns the state |
| sw_state | input | 2 | State commanded in manual mode |
| sw_hold_mode | input | 2 | Holdover source: 0 instant, 1 average, 2/3 free-run |
| cfg_lock_ticks | input | LOCK_CW | Ticks of steady lock needed to enter locked |
| cfg_freerun_word | input | FW | Nominal free-run frequency word |
| sw_irq_clr | input | 1 | Write-1 clear of the state-change flag |
| state | output | 2 | Current state code |
| freq_out | output | FW | Frequency word to apply |
| irq_state_chg | output | 1 | Sticky state-change flag |

## Verification
The bench builds the block with FW=16, AVG_LOG2=3 and LOCK_CW=4. The eight-sample window therefore fills well inside a tick period driven by the bench. A ramp of eight words shows the floor of a fractional average, and a tick arriving before the window fills shows that a partial window is discarded. The four-bit lock count makes the zero setting and a reset of the count by a lock-detect drop quick to reach. Manual forcing of holdover makes the frozen average observable after the loop has fallen back to pre-lock.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
    typedef enum logic [1:0] {
        ST_FREE    = 2'd0,
        ST_PRELOCK = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_HOLD    = 2'd3
    } lmc_state_e;

    localparam logic [1:0] HM_INSTANT = 2'd0;
    localparam logic [1:0] HM_AVERAGE = 2'd1;
endpackage

// File: rtl/lmc_fsm.sv
module lmc_fsm
    import lmc_pkg::*;
#(
    parameter int LOCK_CW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_valid,
    input  logic               lock_det,
    input  logic               tick,
    input  logic               sw_manual,
    input  logic [1:0]         sw_state,
    input  logic [LOCK_CW-1:0] cfg_lock_ticks,
    input  logic               irq_clr,
    output lmc_state_e         state_o,
    output logic               irq_o
);
    typedef struct packed {
        lmc_state_e         st;
        logic [LOCK_CW-1:0] cnt;
        logic               irq;
    } fsm_regs_t;

    fsm_regs_t q, d;
    logic [LOCK_CW:0] target;
    logic [LOCK_CW:0] cnt_inc;

    always_comb begin
        d       = q;
        target  = (cfg_lock_ticks == '0) ? (LOCK_CW+1)'(1) : {1'b0, cfg_lock_ticks};
        cnt_inc = {1'b0, q.cnt} + (LOCK_CW+1)'(1);
        if (sw_manual) begin
            d.st  = lmc_state_e'(sw_state);
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_FREE: begin
                    if (ref_valid) d.st = ST_PRELOCK;
                end
                ST_PRELOCK: begin
                    if (!ref_valid) begin
                        d.st = ST_FREE;
                    end else if (!lock_det) begin
                        d.cnt = '0;
                    end else if (tick) begin
                        if (cnt_inc >= target) d.st = ST_LOCKED;
                        else                   d.cnt = cnt_inc[LOCK_CW-1:0];
                    end
                end
                ST_LOCKED: begin
                    if (!ref_valid)     d.st = ST_HOLD;
                    else if (!lock_det) d.st = ST_PRELOCK;
                end
                default: begin
                    if (ref_valid) d.st = ST_PRELOCK;
                end
            endcase
        end
        if (d.st != q.st) begin
            d.irq = 1'b1;
            d.cnt = '0;
        end else if (irq_clr) begin
            d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= ST_FREE;
            q.cnt <= '0;
            q.irq <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;
    assign irq_o   = q.irq;

    assert_free_to_prelock_R2: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_FREE && ref_valid && !sw_manual) |=> (q.st == ST_PRELOCK));

    assert_locked_loss_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_LOCKED && !ref_valid && !sw_manual) |=> (q.st == ST_HOLD));

    assert_hold_return_R5: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_HOLD && ref_valid && !sw_manual) |=> (q.st == ST_PRELOCK));

    assert_manual_follow_R11: assert property (@(posedge clk) disable iff (rst)
        sw_manual |=> (q.st == $past(lmc_state_e'(sw_state))));

    assert_change_sets_irq_R12: assert property (@(posedge clk) disable iff (rst)
        (q.st != $past(q.st)) |-> q.irq);
endmodule

// File: rtl/lmc_avg.sv
module lmc_avg #(
    parameter int FW       = 16,
    parameter int AVG_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          tick,
    input  logic [FW-1:0] freq_in,
    output logic [FW-1:0] avg_o,
    output logic          valid_o
);
    localparam int AW = FW + AVG_LOG2;
    localparam int NS = 1 << AVG_LOG2;
    localparam logic [AVG_LOG2:0] CNT_FULL = (AVG_LOG2+1)'(NS);

    typedef struct packed {
        logic [AW-1:0]     acc;
        logic [AVG_LOG2:0] cnt;
        logic [FW-1:0]     avg;
        logic              valid;
    } avg_regs_t;

    avg_regs_t q, d;

    always_comb begin
        d = q;
        if (!run) begin
            d.acc = '0;
            d.cnt = '0;
        end else if (tick) begin
            if (q.cnt == CNT_FULL) begin
                d.avg   = q.acc[AW-1:AVG_LOG2];
                d.valid = 1'b1;
            end
            d.acc = '0;
            d.cnt = '0;
        end else if (q.cnt != CNT_FULL) begin
            d.acc = q.acc + AW'(freq_in);
            d.cnt = q.cnt + (AVG_LOG2+1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.acc   <= '0;
            q.cnt   <= '0;
            q.avg   <= '0;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign avg_o   = q.avg;
    assign valid_o = q.valid;

    assert_avg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(q.avg));

    assert_publish_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.valid) |-> $past(run && tick));
endmodule

// File: rtl/lmc_hold_sel.sv
module lmc_hold_sel
    import lmc_pkg::*;
#(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  lmc_state_e    state,
    input  logic [1:0]    hold_mode,
    input  logic [FW-1:0] freq_in,
    input  logic [FW-1:0] freerun_word,
    input  logic [FW-1:0] avg,
    input  logic          avg_valid,
    output logic [FW-1:0] freq_out
);
    typedef struct packed {
        logic [FW-1:0] inst;
    } sel_regs_t;

    sel_regs_t q, d;

    always_comb begin
        d = q;
        if (state == ST_LOCKED) d.inst = freq_in;
    end

    always_ff @(posedge clk) begin
        if (rst) q.inst <= '0;
        else     q <= d;
    end

    always_comb begin
        case (state)
            ST_FREE:    freq_out = freerun_word;
            ST_PRELOCK,
            ST_LOCKED:  freq_out = freq_in;
            default: begin
                if (hold_mode == HM_INSTANT)                   freq_out = q.inst;
                else if (hold_mode == HM_AVERAGE && avg_valid) freq_out = avg;
                else                                           freq_out = freerun_word;
            end
        endcase
    end

    assert_inst_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (state != ST_LOCKED) |=> $stable(q.inst));
endmodule

// File: rtl/loop_mode_ctrl.sv
module loop_mode_ctrl
    import lmc_pkg::*;
#(
    parameter int FW       = 16,
    parameter int AVG_LOG2 = 4,
    parameter int LOCK_CW  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_valid,
    input  logic               lock_det,
    input  logic               tick_1s,
    input  logic [FW-1:0]      freq_in,
    input  logic               sw_manual,
    input  logic [1:0]         sw_state,
    input  logic [1:0]         sw_hold_mode,
    input  logic [LOCK_CW-1:0] cfg_lock_ticks,
    input  logic [FW-1:0]      cfg_freerun_word,
    input  logic               sw_irq_clr,
    output logic [1:0]         state,
    output logic [FW-1:0]      freq_out,
    output logic               irq_state_chg
);
    lmc_state_e    st;
    logic [FW-1:0] avg_word;
    logic          avg_ok;

    lmc_fsm #(.LOCK_CW(LOCK_CW)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .ref_valid      (ref_valid),
        .lock_det       (lock_det),
        .tick           (tick_1s),
        .sw_manual      (sw_manual),
        .sw_state       (sw_state),
        .cfg_lock_ticks (cfg_lock_ticks),
        .irq_clr        (sw_irq_clr),
        .state_o        (st),
        .irq_o          (irq_state_chg)
    );

    lmc_avg #(.FW(FW), .AVG_LOG2(AVG_LOG2)) u_avg (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_LOCKED),
        .tick    (tick_1s),
        .freq_in (freq_in),
        .avg_o   (avg_word),
        .valid_o (avg_ok)
    );

    lmc_hold_sel #(.FW(FW)) u_sel (
        .clk          (clk),
        .rst          (rst),
        .state        (st),
        .hold_mode    (sw_hold_mode),
        .freq_in      (freq_in),
        .freerun_word (cfg_freerun_word),
        .avg          (avg_word),
        .avg_valid    (avg_ok),
        .freq_out     (freq_out)
    );

    assign state = st;

    assert_reset_free_R1: assert property (@(posedge clk)
        $past(rst) |-> (st == ST_FREE && !irq_state_chg));
endmodule

// File: tb/loop_mode_ctrl_test.sv
module loop_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 16;
    localparam int AL = 3;
    localparam int CW = 4;
    localparam logic [FW-1:0] FREERUN = 16'h8000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_valid = 1'b0, lock_det = 1'b0, tick_1s = 1'b0;
    logic [FW-1:0] freq_in = '0;
    logic          sw_manual = 1'b0, sw_irq_clr = 1'b0;
    logic [1:0]    sw_state = '0, sw_hold_mode = '0;
    logic [CW-1:0] cfg_lock_ticks = '0;
    logic [FW-1:0] cfg_freerun_word = FREERUN;
    logic [1:0]    state;
    logic [FW-1:0] freq_out;
    logic          irq_state_chg;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_mode_ctrl #(.FW(FW), .AVG_LOG2(AL), .LOCK_CW(CW)) uut (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .lock_det(lock_det),
        .tick_1s(tick_1s), .freq_in(freq_in), .sw_manual(sw_manual),
        .sw_state(sw_state), .sw_hold_mode(sw_hold_mode),
        .cfg_lock_ticks(cfg_lock_ticks), .cfg_freerun_word(cfg_freerun_word),
        .sw_irq_clr(sw_irq_clr), .state(state), .freq_out(freq_out),
        .irq_state_chg(irq_state_chg)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_tick;
        tick_1s = 1'b1;
        cyc(1);
        tick_1s = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1; ref_valid = 0; lock_det = 0; tick_1s = 0; freq_in = '0;
        sw_manual = 0; sw_state = 0; sw_hold_mode = 0; sw_irq_clr = 0;
        cfg_lock_ticks = 1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic go_locked;
        do_reset();
        ref_valid = 1; lock_det = 1;
        cyc(1);
        pulse_tick();
    endtask

    task automatic t_reset;
        do_reset();
        check("R1 state", state, 0);
        check("R1 irq", irq_state_chg, 0);
        check("R1 freq", freq_out, FREERUN);
    endtask

    task automatic t_acquire;
        do_reset();
        cfg_lock_ticks = 3;
        ref_valid = 1;
        cyc(1);
        check("R2 free->prelock", state, 1);
        lock_det = 1; freq_in = 16'h1234;
        #1 check("R6 prelock live", freq_out, 16'h1234);
        pulse_tick(); pulse_tick();
        check("R3 two of three ticks", state, 1);
        lock_det = 0; cyc(1); lock_det = 1;
        pulse_tick(); pulse_tick();
        check("R3 count cleared by lock drop", state, 1);
        pulse_tick();
        check("R3 locked after three", state, 2);
        freq_in = 16'h4321;
        #1 check("R6 locked live", freq_out, 16'h4321);
        lock_det = 0; cyc(1);
        check("R4 lock loss -> prelock", state, 1);
        ref_valid = 0; cyc(1);
        check("R2 prelock->free", state, 0);
        check("R6 free word", freq_out, FREERUN);
        cfg_lock_ticks = 0; ref_valid = 1; lock_det = 1; cyc(1);
        pulse_tick();
        check("R3 zero acts as one", state, 2);
    endtask

    task automatic t_instant;
        go_locked();
        freq_in = 16'h1111; cyc(3);
        freq_in = 16'h2222; ref_valid = 0; cyc(1);
        check("R4 locked->hold", state, 3);
        freq_in = 16'h5555; sw_hold_mode = 0;
        #1 check("R7 instant hold", freq_out, 16'h2222);
        sw_hold_mode = 2;
        #1 check("R10 mode 2 freerun", freq_out, FREERUN);
        sw_hold_mode = 3;
        #1 check("R10 mode 3 freerun", freq_out, FREERUN);
        ref_valid = 1; cyc(1);
        check("R5 hold->prelock", state, 1);
    endtask

    task automatic t_avg;
        go_locked();
        sw_hold_mode = 1; ref_valid = 0; cyc(1);
        check("R8 no average yet -> freerun", freq_out, FREERUN);
        go_locked();
        sw_hold_mode = 1;
        freq_in = 16'h0200; cyc(3);
        pulse_tick();
        for (int k = 0; k < 8; k++) begin
            freq_in = 16'h1000 + 16'(k);
            cyc(1);
        end
        freq_in = 16'hFFFF; cyc(5);
        pulse_tick();
        freq_in = 16'h2000; cyc(3);
        pulse_tick();
        for (int k = 0; k < 4; k++) begin
            freq_in = 16'h3000; cyc(1);
        end
        pulse_tick();
        ref_valid = 0; cyc(1);
        check("R4 to hold", state, 3);
        check("R8 floor average, partial window dropped", freq_out, 16'h1003);
        ref_valid = 1; lock_det = 0; cyc(1);
        for (int k = 0; k < 12; k++) begin
            freq_in = 16'h7000 + 16'(k); cyc(1);
        end
        pulse_tick(); cyc(10); pulse_tick();
        sw_manual = 1; sw_state = 3; cyc(1);
        check("R9 average frozen outside locked", freq_out, 16'h1003);
    endtask

    task automatic t_manual;
        do_reset();
        sw_manual = 1; sw_state = 2; cyc(1);
        check("R11 forced locked", state, 2);
        ref_valid = 0; lock_det = 0; cyc(3);
        check("R11 auto ignored", state, 2);
        sw_state = 3; cyc(1);
        check("R11 forced hold", state, 3);
        sw_state = 0; ref_valid = 1; cyc(2);
        check("R11 forced free despite ref", state, 0);
        sw_manual = 0; cyc(1);
        check("R2 auto resumes", state, 1);
    endtask

    task automatic t_irq;
        do_reset();
        ref_valid = 1; cyc(1);
        check("R12 set on change", irq_state_chg, 1);
        cyc(3);
        check("R12 sticky", irq_state_chg, 1);
        sw_irq_clr = 1; cyc(1); sw_irq_clr = 0;
        check("R12 cleared", irq_state_chg, 0);
        ref_valid = 0; sw_irq_clr = 1; cyc(1); sw_irq_clr = 0;
        check("R12 set wins over clear", irq_state_chg, 1);
        check("R2 back to free", state, 0);
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_instant();
        t_avg();
        t_manual();
        t_irq();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule